// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block holds the interrupt state of a small peripheral-interface unit: an 8-bit flag register that collects events from two timers and a serial shift unit, and an 8-bit enable register that selects which of those events may reach the processor. Event sources raise flags with single-cycle set pulses. Software clears flags by writing ones to the flag register. The register decoder clears flags as a side effect of reads of the shift data or of a timer counter, and signals this through dedicated clear-request inputs.

The enable register is never loaded directly. Bit 7 of a write chooses whether the ones in bits 6:0 are added to the enable set or taken away from it. On readback, bit 7 of the enable register always reads 1. Bit 7 of the flag register reads as a summary of pending enabled work. The single level interrupt output only considers the timer and shift-complete sources. The serial data and serial clock flags can be enabled and seen in the summary bit, but they never drive the line.

Top module: `irq_flag_enable`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), both registers are zero: a flag read gives 0x00, an enable read gives 0x80, and irq is low.
- R2: A pulse on evt_set[i] sets a flag bit on the next rising edge. The mapping is index 0 to bit 2 (shift done, 0x04), index 1 to bit 3 (serial data, 0x08), index 2 to bit 4 (serial clock, 0x10), index 3 to bit 5 (timer 2, 0x20) and index 4 to bit 6 (timer 1, 0x40).
- R3: A write with wr_sel=1 and wr_data[7]=1 ORs wr_data[6:0] into the enable bits.
- R4: A write with wr_sel=1 and wr_data[7]=0 clears every enable bit whose wr_data bit is 1, and leaves the other enable bits unchanged.
- R5: With rd_sel=1, rd_data gives the enable bits in 6:0, and bit 7 is always 1.
- R6: With rd_sel=0, rd_data gives the flag bits in 6:0, and bit 7 is 1 exactly when some flag bit is set whose enable bit is also set.
- R7: A write with wr_sel=0 clears every flag bit whose wr_data bit is 1. Flag bits 7, 1 and 0 always hold 0, whatever is written.
- R8: irq is high exactly when (flags & enables & 0x64) is nonzero. It follows the registered state, so it changes after the same edge as the register.
- R9: clr_sr clears flag bits 0x04, 0x08 and 0x10. clr_t1 clears 0x40. clr_t2 clears 0x20.
- R10: When a set pulse and a clear (either a write clear or a clear request) hit the same flag bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 flag register, 1 enable register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 flag register, 1 enable register |
| rd_data | output | 8 | Read data, combinational from the registers |
| evt_set | input | 5 | Per-source set pulses (mapping in R2) |
| clr_sr | input | 1 | Clear request for the three shift-related flags |
| clr_t1 | input | 1 | Clear request for the timer 1 flag |
| clr_t2 | input | 1 | Clear request for the timer 2 flag |
| irq | output | 1 | Level interrupt output |

## Verification
The main sequence drives each source on its own, and also several sources at once. This separates a wrong bit mapping from a missing OR. Some flags are enabled but outside the interrupt mask, such as serial data and serial clock. These show whether the summary bit and the irq line are computed from different masks. Enable writes are made with bit 7 set and with bit 7 clear, and they include bit patterns that overlap bits already held, which tells set-mode from clear-mode and from a plain load. Other cycles present a set pulse together with a write clear or a clear request on the same bit, which shows the priority of set over clear.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
    localparam int REG_W    = 8;
    localparam int EN_W     = REG_W - 1;
    localparam int NUM_SRC  = 5;
    localparam int SUM_BIT  = REG_W - 1;

    // flag bit position of each source, indexed by evt_set index
    localparam int SRC_POS [NUM_SRC] = '{2, 3, 4, 5, 6};

    localparam int T2_POS = 5;
    localparam int T1_POS = 6;

    localparam logic [REG_W-1:0] SHIFT_GROUP = 8'h1C;
    localparam logic [REG_W-1:0] IRQ_MASK    = 8'h64;

    typedef struct packed {
        logic [REG_W-1:0] flag;
        logic [EN_W-1:0]  en;
    } irqfe_state_t;
endpackage

// File: rtl/irqfe_flag_next.sv
module irqfe_flag_next
    import irqfe_pkg::*;
(
    input  logic [REG_W-1:0]   flag_q,
    input  logic [NUM_SRC-1:0] evt_set,
    input  logic [REG_W-1:0]   clr_mask,
    output logic [REG_W-1:0]   flag_d
);
    logic [REG_W-1:0] set_vec;

    // scatter the source pulses onto their flag positions
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        logic [NUM_SRC-1:0] hit;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            if (SRC_POS[s] == b) begin : g_map
                assign hit[s] = evt_set[s];
            end else begin : g_nomap
                assign hit[s] = 1'b0;
            end
        end
        assign set_vec[b] = |hit;
    end

    // set has priority over any clear
    always_comb begin
        flag_d = (flag_q & ~clr_mask) | set_vec;
    end
endmodule

// File: rtl/irqfe_en_next.sv
module irqfe_en_next
    import irqfe_pkg::*;
(
    input  logic [EN_W-1:0]  en_q,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wr_data,
    output logic [EN_W-1:0]  en_d
);
    always_comb begin
        en_d = en_q;
        if (en_wr) begin
            if (wr_data[SUM_BIT]) begin
                en_d = en_q | wr_data[EN_W-1:0];
            end else begin
                en_d = en_q & ~wr_data[EN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irqfe_read_mux.sv
module irqfe_read_mux
    import irqfe_pkg::*;
(
    input  logic [REG_W-1:0] flag_q,
    input  logic [EN_W-1:0]  en_q,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    logic [REG_W-1:0] en_full;
    logic [REG_W-1:0] pending;

    always_comb begin
        en_full = {1'b0, en_q};
        pending = flag_q & en_full;
        irq     = |(pending & IRQ_MASK);
        if (rd_sel) begin
            rd_data = {1'b1, en_q};
        end else begin
            rd_data = {|pending, flag_q[EN_W-1:0]};
        end
    end
endmodule

// File: rtl/irq_flag_enable.sv
module irq_flag_enable
    import irqfe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_sel,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0] evt_set,
    input  logic               clr_sr,
    input  logic               clr_t1,
    input  logic               clr_t2,
    output logic               irq
);
    irqfe_state_t     st_d, st_q;
    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] flag_nx;
    logic [EN_W-1:0]  en_nx;
    logic [REG_W-1:0] flag_q;
    logic [EN_W-1:0]  en_q;

    assign flag_q = st_q.flag;
    assign en_q   = st_q.en;

    // gather all clear sources into one mask
    always_comb begin
        clr_mask = '0;
        if (wr_en && !wr_sel) clr_mask = clr_mask | wr_data;
        if (clr_sr)           clr_mask = clr_mask | SHIFT_GROUP;
        if (clr_t1)           clr_mask[T1_POS] = 1'b1;
        if (clr_t2)           clr_mask[T2_POS] = 1'b1;
    end

    irqfe_flag_next u_flag_next (
        .flag_q   (flag_q),
        .evt_set  (evt_set),
        .clr_mask (clr_mask),
        .flag_d   (flag_nx)
    );

    irqfe_en_next u_en_next (
        .en_q    (en_q),
        .en_wr   (wr_en && wr_sel),
        .wr_data (wr_data),
        .en_d    (en_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.flag = flag_nx & {1'b0, {EN_W{1'b1}}};
        st_d.en   = en_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    irqfe_read_mux u_read_mux (
        .flag_q  (flag_q),
        .en_q    (en_q),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .irq     (irq)
    );
endmodule

// File: rtl/irqfe_chk.sv
module irqfe_chk
    import irqfe_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               wr_sel,
    input logic [REG_W-1:0]   wr_data,
    input logic               rd_sel,
    input logic [REG_W-1:0]   rd_data,
    input logic [NUM_SRC-1:0] evt_set,
    input logic               clr_sr,
    input logic               clr_t2,
    input logic [REG_W-1:0]   flag_q,
    input logic [EN_W-1:0]    en_q
);
    // R2
    t1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[4] |=> flag_q[T1_POS]);

    // R10
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set[3] && clr_t2) |=> flag_q[T2_POS]);

    // R9
    shift_group_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sr && evt_set[2:0] == '0) |=> (flag_q & SHIFT_GROUP) == '0);

    // R3
    en_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[SUM_BIT])
            |=> (en_q & $past(wr_data[EN_W-1:0])) == $past(wr_data[EN_W-1:0]));

    // R4
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !wr_data[SUM_BIT])
            |=> (en_q & $past(wr_data[EN_W-1:0])) == '0);

    // R7
    flag_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[T1_POS] && !evt_set[4]) |=> !flag_q[T1_POS]);

    // R5
    en_read_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> rd_data[SUM_BIT]);
endmodule

bind irq_flag_enable irqfe_chk i_irqfe_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .evt_set (evt_set),
    .clr_sr  (clr_sr),
    .clr_t2  (clr_t2),
    .flag_q  (flag_q),
    .en_q    (en_q)
);

// File: tb/test_irq_flag_enable.sv
module test_irq_flag_enable;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [4:0] evt_set = '0;
    logic       clr_sr = 1'b0, clr_t1 = 1'b0, clr_t2 = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_flag_enable i_irq_flag_enable (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_set(evt_set), .clr_sr(clr_sr), .clr_t1(clr_t1),
        .clr_t2(clr_t2), .irq(irq)
    );

    typedef struct packed {
        logic       we;
        logic       wsel;
        logic [7:0] wdata;
        logic [4:0] evt;
        logic       csr;
        logic       ct1;
        logic       ct2;
        logic [7:0] xflag;
        logic [7:0] xen;
        logic       xirq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,8'h00,5'b10000,1'b0,1'b0,1'b0,8'h40,8'h80,1'b0}, // R2 t1
        '{1'b1,1'b1,8'hC0,5'b00000,1'b0,1'b0,1'b0,8'hC0,8'hC0,1'b1}, // R3 R6 R8
        '{1'b1,1'b0,8'h40,5'b00000,1'b0,1'b0,1'b0,8'h00,8'hC0,1'b0}, // R7
        '{1'b0,1'b0,8'h00,5'b00010,1'b0,1'b0,1'b0,8'h08,8'hC0,1'b0}, // R2 data
        '{1'b1,1'b1,8'h88,5'b00000,1'b0,1'b0,1'b0,8'h88,8'hC8,1'b0}, // R6 R8 unmasked
        '{1'b0,1'b0,8'h00,5'b00101,1'b0,1'b0,1'b0,8'h9C,8'hC8,1'b0}, // R2 sr+clk
        '{1'b1,1'b1,8'h84,5'b00000,1'b0,1'b0,1'b0,8'h9C,8'hCC,1'b1}, // R3 R8
        '{1'b0,1'b0,8'h00,5'b00000,1'b1,1'b0,1'b0,8'h00,8'hCC,1'b0}, // R9 sr group
        '{1'b1,1'b1,8'hA0,5'b01000,1'b0,1'b0,1'b0,8'hA0,8'hEC,1'b1}, // R2 R3 t2
        '{1'b0,1'b0,8'h00,5'b01000,1'b0,1'b0,1'b1,8'hA0,8'hEC,1'b1}, // R10 vs clr_t2
        '{1'b0,1'b0,8'h00,5'b00000,1'b0,1'b0,1'b1,8'h00,8'hEC,1'b0}, // R9 t2
        '{1'b1,1'b1,8'h24,5'b00000,1'b0,1'b0,1'b0,8'h00,8'hC8,1'b0}, // R4
        '{1'b1,1'b0,8'h40,5'b10000,1'b0,1'b0,1'b0,8'hC0,8'hC8,1'b1}, // R10 vs write
        '{1'b0,1'b0,8'h00,5'b00000,1'b0,1'b1,1'b0,8'h00,8'hC8,1'b0}, // R9 t1
        '{1'b0,1'b0,8'h00,5'b11111,1'b0,1'b0,1'b0,8'hFC,8'hC8,1'b1}, // R2 all
        '{1'b1,1'b0,8'h14,5'b00000,1'b0,1'b0,1'b0,8'hE8,8'hC8,1'b1}, // R7 partial
        '{1'b0,1'b0,8'h00,5'b00000,1'b1,1'b0,1'b0,8'hE0,8'hC8,1'b1}, // R9 keeps t1 t2
        '{1'b1,1'b1,8'h7F,5'b00000,1'b0,1'b0,1'b0,8'h60,8'h80,1'b0}, // R4 R5 R6
        '{1'b1,1'b1,8'hFF,5'b00000,1'b0,1'b0,1'b0,8'hE0,8'hFF,1'b1}, // R3 R5
        '{1'b1,1'b0,8'h83,5'b00000,1'b0,1'b0,1'b0,8'hE0,8'hFF,1'b1}  // R7 no-op bits
    };

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic read_all(input string req, input logic [7:0] xf,
                            input logic [7:0] xe, input logic xi);
        rd_sel = 1'b0; #1;
        chk8({req, " flag read"}, rd_data, xf);
        rd_sel = 1'b1; #1;
        chk8({req, " enable read"}, rd_data, xe);
        chk8({req, " irq"}, {7'd0, irq}, {7'd0, xi});
        rd_sel = 1'b0;
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; evt_set = '0;
        clr_sr = 1'b0; clr_t1 = 1'b0; clr_t2 = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        idle();
        repeat (2) @(negedge clk);
        read_all("R1 in reset", 8'h00, 8'h80, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1 after release", 8'h00, 8'h80, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i].we; wr_sel = VEC[i].wsel; wr_data = VEC[i].wdata;
            evt_set = VEC[i].evt; clr_sr = VEC[i].csr;
            clr_t1 = VEC[i].ct1; clr_t2 = VEC[i].ct2;
            @(posedge clk);
            #2;
            idle();
            read_all($sformatf("vector %0d", i), VEC[i].xflag, VEC[i].xen, VEC[i].xirq);
        end

        // R7: write of zero to flag register changes nothing
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00;
        @(posedge clk); #2; idle();
        read_all("R7 zero write", 8'hE0, 8'hFF, 1'b1);

        // R9 R10: clr_sr together with a serial clock pulse
        @(negedge clk);
        evt_set = 5'b00100; clr_sr = 1'b1;
        @(posedge clk); #2; idle();
        read_all("R10 clr_sr vs clock", 8'hF0, 8'hFF, 1'b1);

        // R1: reset in the middle of activity
        @(negedge clk);
        rst_n = 1'b0; #1;
        read_all("R1 async reset", 8'h00, 8'h80, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1 held after reset", 8'h00, 8'h80, 1'b0);

        done = 1'b1;
        summary();
    end
endmodule